// File: doc/BRIEF.md
# Video Preamplifier Control Register Slave (I2C, write-only)

This block is the control-plane front end of a video preamplifier. It watches the two I2C bus wires with a fast system clock and recognises START and STOP conditions. Writes addressed to its fixed device address are accepted. A write carries a sub-address byte and then one or more data bytes, and the block stores that data into eight control registers. All register values are presented in parallel to the downstream video datapath: contrast, brightness, three per-channel drive gains, output DC level, OSD contrast and a miscellaneous control byte.

The block only receives. A read request, or any other address byte, is left unacknowledged, and the block then stays silent until the next START. Both bus lines pass through a synchronizer and a short majority-style glitch filter before any edge is interpreted, which suits SCL rates up to 200 kHz with a system clock many times faster. The sub-address advances after every data byte, so a single transaction can load a run of consecutive registers.

Top module: `vpre_i2c_regs`

## Requirements
- R1: After reset, contrast, brightness and the three drive gains read B4 hex, output DC level and OSD contrast read 8, the control byte reads 04 hex, and SDA is released.
- R2: An address byte of DC hex (7-bit address 1101110, then a write bit of 0), sent most significant bit first, is acknowledged: SDA is held low while SCL is high during the ninth clock pulse.
- R3: Any other address byte, including the read form DD hex, is not acknowledged. Later bytes up to the next START are not acknowledged either and change no register.
- R4: After an acknowledged address, the sub-address byte and each data byte are acknowledged. The data byte is stored into the register at that sub-address: 01 contrast, 02 brightness, 03 to 05 drive gain of channels 0 to 2, 06 output DC level, 07 OSD contrast, 08 control byte.
- R5: After each data byte the sub-address increments by one. Successive data bytes in one transaction therefore land in consecutive registers.
- R6: Data bytes aimed at sub-address 00 or at 09 hex and above are acknowledged but discarded. No register changes.
- R7: The output DC level and OSD contrast registers are 4 bits wide and keep only the low nibble of the data byte.
- R8: A low nibble of 0, 1 or 2 written to the output DC level register is stored as 3.
- R9: A START that arrives in the middle of a byte abandons that byte. Address matching begins again with the next eight bits.
- R10: A pulse on SCL that lasts fewer than three system clock samples is ignored and does not shift a bit.
- R11: A transaction that ends with STOP right after the sub-address byte changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | I2C clock line as seen at the pad |
| sdaIn | input | 1 | I2C data line as seen at the pad |
| sdaPullLow | output | 1 | 1 makes the pad pull SDA low (open drain) |
| contrastLvl | output | 8 | Picture contrast setting |
| brightLvl | output | 8 | Brightness offset setting |
| driveLvl | output | 24 | Drive gains, channel 0 in bits 7:0, channel 1 in 15:8, channel 2 in 23:16 |
| dcLevel | output | 4 | Output DC level code, never below 3 |
| osdLevel | output | 4 | OSD contrast code |
| miscCtrl | output | 8 | Miscellaneous control byte |

## Verification
Several internal faults show up at the ports. A bit counter or shift register out of step puts the acknowledge in the wrong slot, so SDA is not low during the ninth pulse of the very byte involved. A wrong sub-address pointer or a bad decode puts data into the wrong parallel output, and that is visible a few system clocks after the STOP. A filter that lets glitches through adds a bit, which moves both the stored value and every later acknowledge in that transaction. The register model in the bench is compared against every output after each transaction, so a stray write is caught before the next transaction starts.

// File: rtl/vpre_ctrl_pkg.sv
package vpre_ctrl_pkg;

  localparam logic [6:0] DEV_ADDR7   = 7'b1101110;

  localparam logic [7:0] SUB_CONTRAST = 8'h01;
  localparam logic [7:0] SUB_BRIGHT   = 8'h02;
  localparam logic [7:0] SUB_DRIVE0   = 8'h03;
  localparam logic [7:0] SUB_DCLVL    = 8'h06;
  localparam logic [7:0] SUB_OSD      = 8'h07;
  localparam logic [7:0] SUB_MISC     = 8'h08;

  localparam logic [7:0] RST_WIDE  = 8'hB4;
  localparam logic [3:0] RST_NIB   = 4'h8;
  localparam logic [7:0] RST_MISC  = 8'h04;
  localparam logic [3:0] DC_FLOOR  = 4'h3;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrAddr;
    logic [7:0] wrData;
  } regWrite_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_ACK,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/vpre_line_filter.sv
module vpre_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;
  logic                   lineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
      histQ <= '1;
      lineQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
      if (&histQ)
        lineQ <= 1'b1;
      else if (~|histQ)
        lineQ <= 1'b0;
    end
  end

  assign lineOut = lineQ;

  // R10: a filtered edge needs the synchronized line at the new level two cycles earlier
  assert_glitch_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineQ) |-> $past(syncQ[SYNC_STAGES-1], 2));
  assert_glitch_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineQ) |-> !$past(syncQ[SYNC_STAGES-1], 2));

endmodule

// File: rtl/vpre_bus_ctrl.sv
module vpre_bus_ctrl
  import vpre_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  output logic      sdaPullLow,
  output regWrite_t regWr
);

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  busState_t            state, afterAck;
  logic                 sclPrev, sdaPrev;
  logic [CNT_W-1:0]     bitCnt;
  logic [BYTE_BITS-1:0] shiftQ;
  logic [7:0]           subPtr;
  logic                 sdaLowQ;
  regWrite_t            wrQ;

  logic sclRise, sclFall, startDet, stopDet, byteDone, inByte;

  assign sclRise  = sclF && !sclPrev;
  assign sclFall  = !sclF && sclPrev;
  assign startDet = sclF && sclPrev && sdaPrev && !sdaF;
  assign stopDet  = sclF && sclPrev && !sdaPrev && sdaF;
  assign byteDone = (bitCnt == CNT_W'(BYTE_BITS));
  assign inByte   = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      shiftQ   <= '0;
      subPtr   <= '0;
      sdaLowQ  <= 1'b0;
      wrQ      <= '0;
    end else begin
      wrQ.wrEn <= 1'b0;
      if (startDet) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        sdaLowQ <= 1'b0;
      end else if (stopDet) begin
        state   <= ST_IDLE;
        bitCnt  <= '0;
        sdaLowQ <= 1'b0;
      end else if (inByte) begin
        if (sclRise && !byteDone) begin
          shiftQ <= {shiftQ[BYTE_BITS-2:0], sdaF};
          bitCnt <= bitCnt + 1'b1;
        end else if (sclFall && byteDone) begin
          bitCnt <= '0;
          unique case (state)
            ST_ADDR: begin
              if (shiftQ == {DEV_ADDR7, 1'b0}) begin
                sdaLowQ  <= 1'b1;
                afterAck <= ST_SUB;
                state    <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_SUB: begin
              subPtr   <= shiftQ;
              sdaLowQ  <= 1'b1;
              afterAck <= ST_DATA;
              state    <= ST_ACK;
            end
            default: begin
              wrQ.wrEn   <= 1'b1;
              wrQ.wrAddr <= subPtr;
              wrQ.wrData <= shiftQ;
              subPtr     <= subPtr + 8'd1;
              sdaLowQ    <= 1'b1;
              afterAck   <= ST_DATA;
              state      <= ST_ACK;
            end
          endcase
        end
      end else if (state == ST_ACK) begin
        if (sclFall) begin
          sdaLowQ <= 1'b0;
          state   <= afterAck;
        end
      end
    end
  end

  assign sdaPullLow = sdaLowQ;
  assign regWr      = wrQ;

  // R2: the acknowledge is only ever asserted while SCL is low
  assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLowQ) |-> !sclF);
  // R3: after a mismatched address the slave stays off the bus
  assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaLowQ);
  // R3: no register write strobe while ignoring
  assert_ignore_nowrite_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |=> !wrQ.wrEn);
  // R9: a START always restarts counting from zero
  assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (bitCnt == '0) && (state == ST_ADDR));
  // R5: consecutive writes go to consecutive sub-addresses
  assert_autoinc_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrQ.wrEn |-> (subPtr == wrQ.wrAddr + 8'd1));

endmodule

// File: rtl/vpre_reg_file.sv
module vpre_reg_file
  import vpre_ctrl_pkg::*;
#(
  parameter int NUM_DRIVE = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regWrite_t              regWr,
  output logic [7:0]             contrastLvl,
  output logic [7:0]             brightLvl,
  output logic [NUM_DRIVE*8-1:0] driveLvl,
  output logic [3:0]             dcLevel,
  output logic [3:0]             osdLevel,
  output logic [7:0]             miscCtrl
);

  logic [7:0] contrastQ, brightQ, miscQ;
  logic [3:0] dcQ, osdQ, dcNib;

  assign dcNib = (regWr.wrData[3:0] < DC_FLOOR) ? DC_FLOOR : regWr.wrData[3:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      contrastQ <= RST_WIDE;
      brightQ   <= RST_WIDE;
      dcQ       <= RST_NIB;
      osdQ      <= RST_NIB;
      miscQ     <= RST_MISC;
    end else if (regWr.wrEn) begin
      unique case (regWr.wrAddr)
        SUB_CONTRAST: contrastQ <= regWr.wrData;
        SUB_BRIGHT:   brightQ   <= regWr.wrData;
        SUB_DCLVL:    dcQ       <= dcNib;
        SUB_OSD:      osdQ      <= regWr.wrData[3:0];
        SUB_MISC:     miscQ     <= regWr.wrData;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_DRIVE; c++) begin : g_drive
    logic [7:0] gainQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        gainQ <= RST_WIDE;
      else if (regWr.wrEn && (regWr.wrAddr == SUB_DRIVE0 + 8'(c)))
        gainQ <= regWr.wrData;
    end
    assign driveLvl[c*8 +: 8] = gainQ;
  end

  assign contrastLvl = contrastQ;
  assign brightLvl   = brightQ;
  assign dcLevel     = dcQ;
  assign osdLevel    = osdQ;
  assign miscCtrl    = miscQ;

  // R8: the DC level never holds a forbidden code
  assert_dc_floor_R8: assert property (@(posedge clk) disable iff (!rstN)
    dcQ >= DC_FLOOR);
  // R4: a strobe to contrast lands in the next cycle
  assert_contrast_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWr.wrEn && regWr.wrAddr == SUB_CONTRAST) |=> (contrastLvl == $past(regWr.wrData)));
  // R6: without a strobe the registers hold
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !regWr.wrEn |=> $stable(contrastQ) && $stable(brightQ) && $stable(miscQ)
                    && $stable(dcQ) && $stable(osdQ) && $stable(driveLvl));

endmodule

// File: rtl/vpre_i2c_regs.sv
module vpre_i2c_regs
  import vpre_ctrl_pkg::*;
#(
  parameter int NUM_DRIVE   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaPullLow,
  output logic [7:0]             contrastLvl,
  output logic [7:0]             brightLvl,
  output logic [NUM_DRIVE*8-1:0] driveLvl,
  output logic [3:0]             dcLevel,
  output logic [3:0]             osdLevel,
  output logic [7:0]             miscCtrl
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines, cleanLines;
  regWrite_t            regWr;

  assign rawLines = {sdaIn, sclIn};

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    vpre_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLines[l]),
      .lineOut(cleanLines[l])
    );
  end

  vpre_bus_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclF      (cleanLines[0]),
    .sdaF      (cleanLines[1]),
    .sdaPullLow(sdaPullLow),
    .regWr     (regWr)
  );

  vpre_reg_file #(.NUM_DRIVE(NUM_DRIVE)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .contrastLvl(contrastLvl),
    .brightLvl  (brightLvl),
    .driveLvl   (driveLvl),
    .dcLevel    (dcLevel),
    .osdLevel   (osdLevel),
    .miscCtrl   (miscCtrl)
  );

endmodule

// File: tb/sim_vpre_i2c_regs.sv
`timescale 1ns/1ps
module sim_vpre_i2c_regs;

  localparam int Q        = 20;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic sdaBus;
  logic [7:0]  contrastLvl, brightLvl, miscCtrl;
  logic [23:0] driveLvl;
  logic [3:0]  dcLevel, osdLevel;

  int checks = 0;
  int errors = 0;
  logic [7:0] expReg [1:8];
  bit   ackExp [$];
  string ackTag [$];
  event ackSlot;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  vpre_i2c_regs u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .contrastLvl(contrastLvl), .brightLvl(brightLvl),
    .driveLvl(driveLvl), .dcLevel(dcLevel), .osdLevel(osdLevel), .miscCtrl(miscCtrl)
  );

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected acknowledge per ninth pulse
  always @(ackSlot) begin
    bit    e;
    string t;
    logic  got;
    got = ~sdaBus;
    e = ackExp.pop_front();
    t = ackTag.pop_front();
    check(got == e, t, {7'd0, got}, {7'd0, e});
  end

  task automatic busStart;
    sdaM = 1; qwait(Q); sclM = 1; qwait(Q); sdaM = 0; qwait(Q); sclM = 0; qwait(Q);
  endtask

  task automatic busStop;
    sdaM = 0; qwait(Q); sclM = 1; qwait(Q); sdaM = 1; qwait(2*Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, input int glitchBit);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; qwait(Q);
      if (i == glitchBit) begin
        sclM = 1; qwait(2); sclM = 0; qwait(Q);
      end
      sclM = 1; qwait(2*Q); sclM = 0; qwait(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input int glitchBit, input string tag);
    sendBits(b, 8, glitchBit);
    sdaM = 1; qwait(Q); sclM = 1; qwait(Q);
    ackExp.push_back(expAck);
    ackTag.push_back(tag);
    -> ackSlot;
    qwait(Q); sclM = 0; qwait(Q);
  endtask

  task automatic modelWrite(input logic [7:0] sub, input logic [7:0] d);
    logic [3:0] nib;
    nib = d[3:0];
    if (sub >= 8'h01 && sub <= 8'h05) expReg[sub[3:0]] = d;
    else if (sub == 8'h06) expReg[6] = {4'h0, (nib < 4'h3) ? 4'h3 : nib};
    else if (sub == 8'h07) expReg[7] = {4'h0, nib};
    else if (sub == 8'h08) expReg[8] = d;
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] act [1:8];
    qwait(10);
    act[1] = contrastLvl; act[2] = brightLvl;
    act[3] = driveLvl[7:0]; act[4] = driveLvl[15:8]; act[5] = driveLvl[23:16];
    act[6] = {4'h0, dcLevel}; act[7] = {4'h0, osdLevel}; act[8] = miscCtrl;
    for (int k = 1; k <= 8; k++)
      check(act[k] === expReg[k], $sformatf("%s reg%0d", tag, k), act[k], expReg[k]);
  endtask

  // full write: address, sub-address, n data bytes, each acknowledged
  task automatic writeBurst(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n, input string tag);
    logic [7:0] dd [3];
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    busStart;
    sendByte(8'hDC, 1, -1, {tag, " addr ack R2"});
    sendByte(sub, 1, -1, {tag, " sub ack R4"});
    for (int k = 0; k < n; k++) begin
      sendByte(dd[k], 1, -1, {tag, " data ack R4"});
      modelWrite(sub + 8'(k), dd[k]);
    end
    busStop;
    checkAll(tag);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 5; k++) expReg[k] = 8'hB4;
    expReg[6] = 8'h08; expReg[7] = 8'h08; expReg[8] = 8'h04;
    qwait(5);
    rstN = 1;
    qwait(5);
    // R1: reset values and released SDA
    check(sdaPullLow == 1'b0, "R1 sda released", {7'd0, sdaPullLow}, 8'h00);
    checkAll("R1 reset");

    // R2, R4: single contrast write
    writeBurst(8'h01, 8'h5A, 8'h00, 8'h00, 1, "R4 contrast");
    // R5: three drive gains in one burst
    writeBurst(8'h03, 8'h11, 8'h22, 8'h33, 3, "R5 autoinc");
    // R7, R6: OSD nibble, control byte, then overflow to sub-address 09
    writeBurst(8'h07, 8'hF5, 8'h9C, 8'h66, 3, "R7 R6 nibble and overflow");
    // R6: sub-address zero discarded
    writeBurst(8'h00, 8'h77, 8'h00, 8'h00, 1, "R6 sub zero");
    // R8: forbidden DC codes are raised to 3
    writeBurst(8'h06, 8'h01, 8'h00, 8'h00, 1, "R8 dc one");
    writeBurst(8'h06, 8'h0A, 8'h00, 8'h00, 1, "R8 dc ten");
    writeBurst(8'h06, 8'h00, 8'h00, 8'h00, 1, "R8 dc zero");
    writeBurst(8'h06, 8'hF2, 8'h00, 8'h00, 1, "R8 R7 dc high nibble");

    // R3: wrong address, then read address; nothing acked or written
    busStart;
    sendByte(8'hDE, 0, -1, "R3 wrong addr");
    sendByte(8'h02, 0, -1, "R3 sub ignored");
    sendByte(8'h99, 0, -1, "R3 data ignored");
    busStop;
    checkAll("R3 wrong addr");
    busStart;
    sendByte(8'hDD, 0, -1, "R3 read addr");
    sendByte(8'h01, 0, -1, "R3 read sub ignored");
    busStop;
    checkAll("R3 read addr");

    // R9: START after three bits of a byte restarts matching
    busStart;
    sendByte(8'hDC, 1, -1, "R9 addr ack");
    sendBits(8'h02, 3, -1);
    busStart;
    sendByte(8'hDC, 1, -1, "R9 re-addr ack");
    sendByte(8'h02, 1, -1, "R9 sub ack");
    sendByte(8'hC3, 1, -1, "R9 data ack");
    modelWrite(8'h02, 8'hC3);
    busStop;
    checkAll("R9 restart");

    // R10: short SCL glitch inside a data byte has no effect
    busStart;
    sendByte(8'hDC, 1, -1, "R10 addr ack");
    sendByte(8'h08, 1, -1, "R10 sub ack");
    sendByte(8'hA5, 1, 4, "R10 glitch data ack");
    modelWrite(8'h08, 8'hA5);
    busStop;
    checkAll("R10 glitch");

    // R11: STOP right after the sub-address
    busStart;
    sendByte(8'hDC, 1, -1, "R11 addr ack");
    sendByte(8'h05, 1, -1, "R11 sub ack");
    busStop;
    checkAll("R11 no data");

    qwait(20);
    check(ackExp.size() == 0, "R2 ack queue drained", 8'(ackExp.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule